// File: doc/BRIEF.md
# DMA Command Queue Register Front-End

This block sits between a host processor's register bus and a DMA engine. The host first stages a transfer descriptor in write-only registers: a local-store address, a 64-bit effective address, and a word that packs the size and the tag group. It then writes a word that packs the class and the opcode. That final write commits the descriptor into a small in-order command queue. Reading the same word back reports whether the command was accepted, must be retried because the queue is full, or was rejected as malformed. The oldest queued descriptor is presented on a set of mover-side outputs.

The block tracks completion per tag group rather than per command. A tag group counts as done when no queued command carries its tag. The host arms a query by writing a group mask and then a query type, and then polls the query-type register until it reads zero. At that point the tag-status register holds the masked groups that were done. A fixed-latency model retires the head command in place of a real data mover.

Top module: `dma_cmdq_regs`

## Requirements
- R1: Reset (synchronous, active high) leaves the queue empty. The free count reads 16, tag status reads all ones, query type reads 0, enqueue status reads 0 and the mover-side valid is low.
- R2: Register word addresses are 0 local-store address, 1 effective address low, 2 effective address high, 3 size/tag (size in bits 31:16, tag in 15:0), 4 class/opcode (class in bits 31:16, opcode in 15:0), 5 free count, 6 tag status, 7 query mask, 8 query type. A write to address 4 with a legal staged size/tag enqueues the command, status reads 0 in bits 15:0 of address 4, and the head outputs present the staged fields.
- R3: A staged tag of 32 or more, a size of 0, or a size above 16384 gives status 1, and the free count is unchanged.
- R4: A legal commit while 16 commands are queued gives status 2 and enqueues nothing.
- R5: Commands retire in FIFO order. The head retires 8 cycles after it became head (a push into an empty queue is retired at the 8th following clock edge).
- R6: The free count equals 16 minus the number of queued commands.
- R7: Query type 1 (any) completes in the cycle after any masked group is done. Tag status then latches the mask ANDed with the done groups.
- R8: Query type 2 (all) completes only once every masked group is done, and latches the same way as R7.
- R9: The query type reads nonzero while a query is pending. Writes to the mask or type during that time are ignored.
- R10: Writing a query type of 0 or of any value above 2 leaves the query idle and tag status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| mv_valid | output | 1 | A command is queued |
| mv_lsa | output | 32 | Head local-store address |
| mv_ea | output | 64 | Head effective address |
| mv_size | output | 16 | Head transfer size |
| mv_tag | output | 5 | Head tag group |
| mv_class | output | 16 | Head class ID |
| mv_opcode | output | 16 | Head opcode |

## Verification
Commits are driven with a table of size/tag pairs on both sides of each legality limit (zero, 16384, 16385, tag 31 and 32, oversized tag fields), which separates accepted from rejected descriptors. A single-cycle commit burst reaches the full queue and separates the retry code from the invalid code. Queries use two groups that retire 8 cycles apart under both query types: an "any" query latches only the earlier group, an "all" query waits for the later one, and the exact clearing cycle shows the one-cycle evaluation lag. Writes made while a query is pending, and illegal type codes, are shown to have no effect on the query-type and tag-status reads.

// File: rtl/dmaq_pkg.sv
`timescale 1ns/1ps
package dmaq_pkg;
   localparam int ADDR_W = 4;

   typedef enum logic [ADDR_W-1:0] {
      REG_LSA       = 4'd0,
      REG_EA_LO     = 4'd1,
      REG_EA_HI     = 4'd2,
      REG_SIZE_TAG  = 4'd3,
      REG_CLASS_CMD = 4'd4,
      REG_FREE      = 4'd5,
      REG_TAG_DONE  = 4'd6,
      REG_QMASK     = 4'd7,
      REG_QTYPE     = 4'd8
   } reg_addr_e;

   localparam logic [15:0] ST_OK      = 16'd0;
   localparam logic [15:0] ST_INVALID = 16'd1;
   localparam logic [15:0] ST_RETRY   = 16'd2;

   localparam logic [1:0] QT_IDLE = 2'd0;
   localparam logic [1:0] QT_ANY  = 2'd1;
   localparam logic [1:0] QT_ALL  = 2'd2;
endpackage

// File: rtl/dmaq_fifo.sv
`timescale 1ns/1ps
module dmaq_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         push,
   input  logic                         pop,
   input  logic [W-1:0]                 din,
   output logic [W-1:0]                 dout,
   output logic [$clog2(DEPTH+1)-1:0]   count
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH+1);
   localparam bit POW2  = (DEPTH & (DEPTH - 1)) == 0;

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   generate
      if (POW2) begin : g_wrap_nat
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

   assign dout = mem[rd_ptr];
endmodule

// File: rtl/dmaq_retire.sv
`timescale 1ns/1ps
module dmaq_retire #(
   parameter int DEPTH   = 16,
   parameter int NTAGS   = 32,
   parameter int LATENCY = 8
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      busy,
   input  logic                      push,
   input  logic [$clog2(NTAGS)-1:0]  push_tag,
   input  logic [$clog2(NTAGS)-1:0]  head_tag,
   output logic                      pop,
   output logic [NTAGS-1:0]          done
);
   localparam int TAG_W = $clog2(NTAGS);
   localparam int T_W   = $clog2(LATENCY);
   localparam int CNT_W = $clog2(DEPTH+1);

   logic [T_W-1:0] timer;

   assign pop = busy && (timer == T_W'(LATENCY-1));

   always_ff @(posedge clk) begin
      if (rst || pop || !busy) timer <= '0;
      else                     timer <= timer + 1'b1;
   end

   generate
      for (genvar t = 0; t < NTAGS; t++) begin : g_tag
         logic [CNT_W-1:0] pend;
         logic inc, dec;
         assign inc = push && (push_tag == TAG_W'(t));
         assign dec = pop  && (head_tag == TAG_W'(t));
         always_ff @(posedge clk) begin
            if (rst)               pend <= '0;
            else if (inc && !dec)  pend <= pend + CNT_W'(1);
            else if (dec && !inc)  pend <= pend - CNT_W'(1);
         end
         assign done[t] = (pend == '0);
      end
   endgenerate
endmodule

// File: rtl/dmaq_query.sv
`timescale 1ns/1ps
module dmaq_query
   import dmaq_pkg::*;
#(
   parameter int NTAGS = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_mask,
   input  logic              wr_type,
   input  logic [31:0]       wdata,
   input  logic [NTAGS-1:0]  done,
   output logic [1:0]        qtype,
   output logic [NTAGS-1:0]  tag_status
);
   logic [NTAGS-1:0] mask_q;
   logic hit_any, hit_all, met, legal_type;

   assign hit_any    = |(mask_q & done);
   assign hit_all    = &(~mask_q | done);
   assign met        = ((qtype == QT_ANY) && hit_any) || ((qtype == QT_ALL) && hit_all);
   assign legal_type = (wdata == 32'd1) || (wdata == 32'd2);

   always_ff @(posedge clk) begin
      if (rst) begin
         mask_q     <= '0;
         qtype      <= QT_IDLE;
         tag_status <= '1;
      end else if (qtype == QT_IDLE) begin
         if (wr_mask)               mask_q <= wdata[NTAGS-1:0];
         if (wr_type && legal_type) qtype  <= wdata[1:0];
      end else if (met) begin
         qtype      <= QT_IDLE;
         tag_status <= mask_q & done;
      end
   end
endmodule

// File: rtl/dma_cmdq_regs.sv
`timescale 1ns/1ps
module dma_cmdq_regs
   import dmaq_pkg::*;
#(
   parameter int DEPTH    = 16,
   parameter int NTAGS    = 32,
   parameter int LATENCY  = 8,
   parameter int MAX_SIZE = 16384
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [31:0]               wdata,
   output logic [31:0]               rdata,
   output logic                      mv_valid,
   output logic [31:0]               mv_lsa,
   output logic [63:0]               mv_ea,
   output logic [15:0]               mv_size,
   output logic [$clog2(NTAGS)-1:0]  mv_tag,
   output logic [15:0]               mv_class,
   output logic [15:0]               mv_opcode
);
   localparam int TAG_W = $clog2(NTAGS);
   localparam int CNT_W = $clog2(DEPTH+1);

   initial begin
      assert (DEPTH >= 2) else $error("DEPTH must be at least 2");
      assert (NTAGS >= 2 && NTAGS <= 32) else $error("NTAGS must be 2..32");
      assert (LATENCY >= 2) else $error("LATENCY must be at least 2");
      assert (MAX_SIZE > 0 && MAX_SIZE < 65536) else $error("MAX_SIZE out of range");
   end

   typedef struct packed {
      logic [31:0]      lsa;
      logic [63:0]      ea;
      logic [15:0]      size;
      logic [TAG_W-1:0] tag;
      logic [15:0]      cls;
      logic [15:0]      op;
   } cmd_t;
   localparam int CMD_W = $bits(cmd_t);

   logic [31:0]      lsa_q;
   logic [63:0]      ea_q;
   logic [15:0]      size_q, tag_raw_q, status_q;
   logic [CNT_W-1:0] fifo_count, free_cnt;
   logic [CMD_W-1:0] fifo_dout;
   logic [NTAGS-1:0] done, tag_status;
   logic [1:0]       qtype;
   cmd_t             staged, head;
   logic             commit, legal, full, push, pop, busy, wr_qtype, wr_qmask;

   assign commit   = wr_en && (addr == REG_CLASS_CMD);
   assign wr_qtype = wr_en && (addr == REG_QTYPE);
   assign wr_qmask = wr_en && (addr == REG_QMASK);
   assign legal    = (tag_raw_q < 16'(NTAGS)) && (size_q != '0) && (size_q <= 16'(MAX_SIZE));
   assign full     = (fifo_count == CNT_W'(DEPTH));
   assign busy     = (fifo_count != '0);
   assign push     = commit && legal && !full;
   assign free_cnt = CNT_W'(DEPTH) - fifo_count;

   assign staged = '{lsa: lsa_q, ea: ea_q, size: size_q, tag: tag_raw_q[TAG_W-1:0],
                     cls: wdata[31:16], op: wdata[15:0]};

   always_ff @(posedge clk) begin
      if (rst) begin
         lsa_q     <= '0;
         ea_q      <= '0;
         size_q    <= '0;
         tag_raw_q <= '0;
         status_q  <= ST_OK;
      end else if (wr_en) begin
         case (addr)
            REG_LSA:       lsa_q        <= wdata;
            REG_EA_LO:     ea_q[31:0]   <= wdata;
            REG_EA_HI:     ea_q[63:32]  <= wdata;
            REG_SIZE_TAG: begin
               size_q    <= wdata[31:16];
               tag_raw_q <= wdata[15:0];
            end
            REG_CLASS_CMD: status_q <= !legal ? ST_INVALID : (full ? ST_RETRY : ST_OK);
            default: ;
         endcase
      end
   end

   dmaq_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst(rst), .push(push), .pop(pop),
      .din(staged), .dout(fifo_dout), .count(fifo_count)
   );

   assign head = cmd_t'(fifo_dout);

   dmaq_retire #(.DEPTH(DEPTH), .NTAGS(NTAGS), .LATENCY(LATENCY)) u_retire (
      .clk(clk), .rst(rst), .busy(busy), .push(push),
      .push_tag(staged.tag), .head_tag(head.tag), .pop(pop), .done(done)
   );

   dmaq_query #(.NTAGS(NTAGS)) u_query (
      .clk(clk), .rst(rst), .wr_mask(wr_qmask), .wr_type(wr_qtype),
      .wdata(wdata), .done(done), .qtype(qtype), .tag_status(tag_status)
   );

   always_comb begin
      case (addr)
         REG_CLASS_CMD: rdata = {16'h0000, status_q};
         REG_FREE:      rdata = 32'(free_cnt);
         REG_TAG_DONE:  rdata = 32'(tag_status);
         REG_QTYPE:     rdata = 32'(qtype);
         default:       rdata = '0;
      endcase
   end

   assign mv_valid  = busy;
   assign mv_lsa    = head.lsa;
   assign mv_ea     = head.ea;
   assign mv_size   = head.size;
   assign mv_tag    = head.tag;
   assign mv_class  = head.cls;
   assign mv_opcode = head.op;
endmodule

// File: rtl/dmaq_checker.sv
`timescale 1ns/1ps
module dmaq_checker #(
   parameter int DEPTH = 16
) (
   input logic                        clk,
   input logic                        rst,
   input logic                        push,
   input logic                        pop,
   input logic [$clog2(DEPTH+1)-1:0]  count,
   input logic [1:0]                  qtype,
   input logic                        wr_qtype
);
   localparam int CNT_W = $clog2(DEPTH+1);

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
      count <= CNT_W'(DEPTH));

   p_push_room_r4: assert property (@(posedge clk) disable iff (rst)
      push |-> (count < CNT_W'(DEPTH)));

   p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (rst)
      pop |-> (count != '0));

   p_qtype_legal_r10: assert property (@(posedge clk) disable iff (rst)
      qtype <= 2'd2);

   p_pending_holds_r9: assert property (@(posedge clk) disable iff (rst)
      (qtype != 2'd0) |=> (qtype == $past(qtype) || qtype == 2'd0));

   p_idle_holds_r10: assert property (@(posedge clk) disable iff (rst)
      (qtype == 2'd0 && !wr_qtype) |=> (qtype == 2'd0));
endmodule

bind dma_cmdq_regs dmaq_checker #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst(rst), .push(push), .pop(pop),
   .count(fifo_count), .qtype(qtype), .wr_qtype(wr_qtype)
);

// File: tb/tb_dma_cmdq_regs.sv
`timescale 1ns/1ps
module tb_dma_cmdq_regs;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        mv_valid;
   logic [31:0] mv_lsa;
   logic [63:0] mv_ea;
   logic [15:0] mv_size, mv_class, mv_opcode;
   logic [4:0]  mv_tag;

   int errs = 0;
   int checks = 0;
   logic [31:0] v;

   always #4 clk = ~clk;

   dma_cmdq_regs dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .mv_valid(mv_valid), .mv_lsa(mv_lsa), .mv_ea(mv_ea), .mv_size(mv_size),
      .mv_tag(mv_tag), .mv_class(mv_class), .mv_opcode(mv_opcode)
   );

   // size, tag, expected status
   localparam logic [47:0] VEC [8] = '{
      {16'd16,     16'd0,      16'd0},
      {16'd16384,  16'd31,     16'd0},
      {16'd16385,  16'd1,      16'd1},
      {16'd0,      16'd3,      16'd1},
      {16'd128,    16'd32,     16'd1},
      {16'd1,      16'd5,      16'd0},
      {16'd64,     16'hFFFF,   16'd1},
      {16'h8000,   16'd2,      16'd1}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] val);
      addr = a;
      #1;
      val = rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sub(input logic [15:0] sz, input logic [15:0] tg,
                      input logic [15:0] cl, input logic [15:0] op);
      wr(4'd3, {sz, tg});
      wr(4'd4, {cl, op});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      idle(3);
      rst = 1'b0;
      // R1 reset state
      rd(4'd5, v); chk("R1 free", v, 16);
      rd(4'd6, v); chk("R1 tagstatus", v, 32'hFFFF_FFFF);
      rd(4'd8, v); chk("R1 qtype", v, 0);
      rd(4'd4, v); chk("R1 status", v, 0);
      chk("R1 mv_valid", mv_valid, 0);

      // R2 R3 table of commits
      for (int i = 0; i < 8; i++) begin
         sub(VEC[i][47:32], VEC[i][31:16], 16'd0, 16'd1);
         rd(4'd4, v);
         chk(VEC[i][15:0] == 0 ? "R2 status" : "R3 status", v, 64'(VEC[i][15:0]));
         rd(4'd5, v);
         chk(VEC[i][15:0] == 0 ? "R2 free" : "R3 free", v, VEC[i][15:0] == 0 ? 15 : 16);
         idle(12);
      end

      // R2 head descriptor fields
      wr(4'd0, 32'h1234_5670);
      wr(4'd1, 32'hDEAD_BEEF);
      wr(4'd2, 32'h0000_00AB);
      sub(16'd256, 16'd6, 16'h0003, 16'h0040);
      chk("R2 valid", mv_valid, 1);
      chk("R2 lsa", mv_lsa, 32'h1234_5670);
      chk("R2 ea", mv_ea, 64'h0000_00AB_DEAD_BEEF);
      chk("R2 size", mv_size, 256);
      chk("R2 tag", mv_tag, 6);
      chk("R2 class", mv_class, 3);
      chk("R2 opcode", mv_opcode, 16'h40);
      idle(12);

      // R5 FIFO order and latency
      sub(16'd8, 16'd3, 16'd0, 16'd1);
      sub(16'd8, 16'd7, 16'd0, 16'd1);
      idle(5); chk("R5 head before first retire", mv_tag, 3);
      idle(1); chk("R5 second at head", mv_tag, 7);
      idle(7); chk("R5 second still queued", mv_valid, 1);
      idle(1); chk("R5 drained", mv_valid, 0);
      idle(4);

      // R4 R6 full queue via single-cycle commit burst
      wr(4'd3, {16'd32, 16'd9});
      for (int i = 0; i < 19; i++) wr(4'd4, {16'd0, 16'd16});
      rd(4'd4, v); chk("R4 retry status", v, 2);
      rd(4'd5, v); chk("R6 free at full", v, 0);
      idle(6);
      rd(4'd5, v); chk("R6 free after retire", v, 1);
      wr(4'd4, {16'd0, 16'd16});
      rd(4'd4, v); chk("R4 accept after room", v, 0);
      rd(4'd5, v); chk("R6 free refilled", v, 0);
      idle(140);
      rd(4'd5, v); chk("R6 free drained", v, 16);

      // R7 R9 any-query across two groups
      sub(16'd8, 16'd4, 16'd0, 16'd1);
      sub(16'd8, 16'd5, 16'd0, 16'd1);
      wr(4'd7, 32'h30);
      wr(4'd8, 32'd1);
      rd(4'd8, v); chk("R9 pending any", v, 1);
      wr(4'd7, 32'h0);
      wr(4'd8, 32'd2);
      rd(4'd8, v); chk("R9 type write ignored", v, 1);
      idle(2);
      rd(4'd8, v); chk("R7 still pending", v, 1);
      idle(1);
      rd(4'd8, v); chk("R7 cleared", v, 0);
      rd(4'd6, v); chk("R7 tagstatus", v, 32'h10);
      idle(20);

      // R8 all-query
      sub(16'd8, 16'd1, 16'd0, 16'd1);
      sub(16'd8, 16'd2, 16'd0, 16'd1);
      wr(4'd7, 32'h406);
      wr(4'd8, 32'd2);
      idle(12);
      rd(4'd8, v); chk("R8 pending until last", v, 2);
      idle(1);
      rd(4'd8, v); chk("R8 cleared", v, 0);
      rd(4'd6, v); chk("R8 tagstatus", v, 32'h406);

      // R9 immediate any on idle group
      wr(4'd7, 32'h200);
      wr(4'd8, 32'd1);
      rd(4'd8, v); chk("R9 pending one cycle", v, 1);
      idle(1);
      rd(4'd8, v); chk("R7 immediate clear", v, 0);
      rd(4'd6, v); chk("R7 immediate tagstatus", v, 32'h200);

      // R10 illegal and zero types
      wr(4'd7, 32'hFF);
      wr(4'd8, 32'd3);
      rd(4'd8, v); chk("R10 type 3", v, 0);
      wr(4'd8, 32'd0);
      rd(4'd8, v); chk("R10 type 0", v, 0);
      idle(2);
      rd(4'd6, v); chk("R10 tagstatus unchanged", v, 32'h200);

      // R1 reset mid-operation
      sub(16'd8, 16'd11, 16'd0, 16'd1);
      rst = 1'b1;
      idle(1);
      rst = 1'b0;
      rd(4'd5, v); chk("R1 free after reset", v, 16);
      rd(4'd6, v); chk("R1 tagstatus after reset", v, 32'hFFFF_FFFF);
      chk("R1 valid after reset", mv_valid, 0);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule